// File: doc/BRIEF.md
# Stream Transfer Trace Monitor

This block sits beside one AXI4-Stream link, for example between a data mover and an accelerator, and watches it without taking part. It sees only the handshake and end-of-packet signals, drives nothing back onto the link, and never stalls it. For each transfer it raises a one-cycle start event on the first accepted beat and a one-cycle stop event on the accepted beat that carries TLAST. Timestamping and merging of these events are done by logic outside the block.

A build-time parameter picks one of two variants. The event-only variant is the default and produces just the two pulses. The counting variant also has an AXI4-Lite slave with two 32-bit read-only words. One word gives the running beat count of the transfer now in progress. The other gives the total beat count of the most recently finished transfer. When a transfer ends, its count, including the TLAST beat, moves into the second word and the running count starts again from zero.

Top module: `strm_xfer_probe`

## Requirements
- R1: A beat is accepted only on a rising clock edge where mon_valid and mon_ready are both 1. Cycles in which either is 0 neither count nor produce events, even when mon_last is 1.
- R2: evt_start is 1 for exactly the one cycle after the clock edge that accepts the first beat following reset or following an accepted TLAST beat. It is 0 otherwise.
- R3: evt_stop is 1 for exactly the one cycle after the clock edge that accepts a beat with mon_last = 1. A single-beat transfer raises evt_start and evt_stop in the same cycle.
- R4: In the counting variant, a read at byte offset 0x0 returns the number of beats accepted so far in the unfinished transfer, zero-extended to 32 bits. It returns 0 when no transfer is open.
- R5: When the TLAST beat is accepted, the word at byte offset 0x4 takes the full beat count of that transfer, including the TLAST beat, and the offset 0x0 count returns to 0.
- R6: The offset 0x4 word keeps its value while the next transfer is in progress, until that transfer completes.
- R7: Writes to any offset complete with bresp = 2'b00 (OKAY) and change no register value.
- R8: Reads at byte offsets other than 0x0 and 0x4 (0x8 and 0xC in the default 4-bit address space) return 0 with rresp = 2'b00.
- R9: While s_rvalid is 1 and s_rready is 0, s_rvalid stays 1 and s_rdata keeps the value captured at the read address handshake, even if beats keep arriving.
- R10: A synchronous active-low reset clears both counts, drops both event outputs and returns the monitor to idle, so the next accepted beat raises evt_start.
- R11: With STATS_EN = 0 (the default), the events behave exactly as in the counting variant, and every AXI4-Lite output stays 0 whatever is driven onto the AXI4-Lite inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed stream |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_valid | input | 1 | Observed TVALID |
| mon_ready | input | 1 | Observed TREADY |
| mon_last | input | 1 | Observed TLAST |
| evt_start | output | 1 | Transfer start pulse |
| evt_stop | output | 1 | Transfer stop pulse |
| s_awaddr | input | ADDR_W | AXI4-Lite write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data (discarded) |
| s_wstrb | input | DATA_W/8 | Write strobes (discarded) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The assertions assume that the observed stream and the register port follow their protocol handshakes. Addresses and write data are held steady while their valid is high and not yet accepted, and a master never depends on ready before it raises valid. The count checks also assume that no transfer reaches 2^CNT_W beats. The bench drives every input on the falling edge and holds each request until the handshake completes. Its transfers are a few beats long, and its register accesses never overlap, so the stimulus stays inside these assumptions.

// File: rtl/strm_probe_pkg.sv
// Package: shared types and constants for the stream transfer trace monitor.
// Assumes: register words are 32 bits, byte-addressed, word aligned.
package strm_probe_pkg;

    localparam logic [1:0] RESP_OKAY    = 2'b00;
    localparam int         WORD_LIVE    = 0;   // byte offset 0x0
    localparam int         WORD_LAST    = 1;   // byte offset 0x4

    // One observed stream beat, already reduced to what the monitor needs.
    typedef struct packed {
        logic accept;   // TVALID && TREADY at this edge
        logic last;     // TLAST on this beat
    } beat_t;

endpackage

// File: rtl/xfer_event_gen.sv
// Module: xfer_event_gen
// Turns accepted beats into registered start/stop pulses.
// Assumes: beat.accept is qualified by the stream handshake; the pulses
// appear in the cycle after the edge that accepts the beat.
module xfer_event_gen
    import strm_probe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t beat,
    output logic  evt_start,
    output logic  evt_stop
);

    logic in_xfer;

    // Track whether a transfer is open between its first and TLAST beats.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_xfer <= 1'b0;
        else if (beat.accept)
            in_xfer <= !beat.last;
    end

    // Register one-cycle event pulses for the beat just accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_start <= 1'b0;
            evt_stop  <= 1'b0;
        end else begin
            evt_start <= beat.accept && !in_xfer;
            evt_stop  <= beat.accept && beat.last;
        end
    end

endmodule

// File: rtl/beat_tally.sv
// Module: beat_tally
// Counts beats of the open transfer and keeps the total of the last one.
// Assumes: a transfer shorter than 2**CNT_W beats; the count wraps beyond.
module beat_tally
    import strm_probe_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  beat_t            beat,
    output logic [CNT_W-1:0] live_cnt,
    output logic [CNT_W-1:0] last_cnt
);

    logic [CNT_W-1:0] live_inc;
    assign live_inc = live_cnt + CNT_W'(1);

    // Advance the live count; on TLAST hand the total over and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
            last_cnt <= '0;
        end else if (beat.accept) begin
            if (beat.last) begin
                last_cnt <= live_inc;
                live_cnt <= '0;
            end else begin
                live_cnt <= live_inc;
            end
        end
    end

    // R1: without an accepted beat neither count moves.
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !beat.accept |=> ($stable(live_cnt) && $stable(last_cnt)));

endmodule

// File: rtl/lite_reg_port.sv
// Module: lite_reg_port
// Read-only AXI4-Lite slave over the two count words.
// Assumes: one outstanding read and one outstanding write; writes are
// acknowledged OKAY and discarded.
module lite_reg_port
    import strm_probe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [CNT_W-1:0]  last_cnt,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    localparam int IDX_W = ADDR_W - 2;

    logic              wr_take;
    logic              rd_take;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wr;

    assign unused_wr = ^{s_awaddr, s_wdata, s_wstrb, s_araddr[1:0]};

    // Accept address and data of a write together when no response waits.
    assign wr_take   = s_awvalid && s_wvalid && !s_bvalid;
    assign s_awready = wr_take;
    assign s_wready  = wr_take;
    assign s_bresp   = RESP_OKAY;

    // Accept a read address whenever no read data is pending.
    assign s_arready = !s_rvalid;
    assign rd_take   = s_arvalid && s_arready;
    assign s_rresp   = RESP_OKAY;
    assign rd_idx    = s_araddr[ADDR_W-1:2];

    // Select the addressed word; unmapped words read zero.
    always_comb begin
        if (rd_idx == IDX_W'(WORD_LIVE))
            rd_word = DATA_W'(live_cnt);
        else if (rd_idx == IDX_W'(WORD_LAST))
            rd_word = DATA_W'(last_cnt);
        else
            rd_word = '0;
    end

    // Hold the write response until the master takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_bvalid <= 1'b0;
        else if (wr_take)
            s_bvalid <= 1'b1;
        else if (s_bready)
            s_bvalid <= 1'b0;
    end

    // Capture read data at the address handshake and hold it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_take) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_word;
        end else if (s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    // R9: pending read data neither vanishes nor changes.
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R7: a write response stays until accepted.
    assert_bresp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

// File: rtl/strm_xfer_probe.sv
// Module: strm_xfer_probe (top)
// Passive trace monitor for one AXI4-Stream link: start/stop pulses per
// transfer, plus optional beat counters read over AXI4-Lite.
// Assumes: stream and register port share clk; STATS_EN = 0 builds the
// event-only variant with the register outputs held at zero.
module strm_xfer_probe
    import strm_probe_pkg::*;
#(
    parameter bit STATS_EN = 1'b0,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic              mon_ready,
    input  logic              mon_last,
    output logic              evt_start,
    output logic              evt_stop,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    beat_t beat;

    // Reduce the observed stream to accepted beats.
    assign beat.accept = mon_valid && mon_ready;
    assign beat.last   = mon_last;

    xfer_event_gen u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .evt_start (evt_start),
        .evt_stop  (evt_stop)
    );

    generate
        if (STATS_EN) begin : g_stats
            logic [CNT_W-1:0] live_cnt;
            logic [CNT_W-1:0] last_cnt;

            beat_tally #(.CNT_W(CNT_W)) u_tally (
                .clk      (clk),
                .rst_n    (rst_n),
                .beat     (beat),
                .live_cnt (live_cnt),
                .last_cnt (last_cnt)
            );

            lite_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
                .clk       (clk),
                .rst_n     (rst_n),
                .live_cnt  (live_cnt),
                .last_cnt  (last_cnt),
                .s_awaddr  (s_awaddr),
                .s_awvalid (s_awvalid),
                .s_awready (s_awready),
                .s_wdata   (s_wdata),
                .s_wstrb   (s_wstrb),
                .s_wvalid  (s_wvalid),
                .s_wready  (s_wready),
                .s_bresp   (s_bresp),
                .s_bvalid  (s_bvalid),
                .s_bready  (s_bready),
                .s_araddr  (s_araddr),
                .s_arvalid (s_arvalid),
                .s_arready (s_arready),
                .s_rdata   (s_rdata),
                .s_rresp   (s_rresp),
                .s_rvalid  (s_rvalid),
                .s_rready  (s_rready)
            );

            // R5: after a stop event the live count has restarted.
            assert_stop_clears_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
                evt_stop |-> (live_cnt == '0));

            // R5: a finished transfer always leaves a non-zero total.
            assert_stop_total_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
                evt_stop |-> (last_cnt != '0));

            // R2: a start without stop means exactly one beat is counted.
            assert_start_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_start && !evt_stop) |-> (live_cnt == CNT_W'(1)));
        end else begin : g_basic
            logic unused_lite;

            // Event-only variant: register port is absent and reads as zero.
            assign s_awready = 1'b0;
            assign s_wready  = 1'b0;
            assign s_bresp   = 2'b00;
            assign s_bvalid  = 1'b0;
            assign s_arready = 1'b0;
            assign s_rdata   = '0;
            assign s_rresp   = 2'b00;
            assign s_rvalid  = 1'b0;
            assign unused_lite = ^{s_awaddr, s_awvalid, s_wdata, s_wstrb, s_wvalid,
                                   s_bready, s_araddr, s_arvalid, s_rready};
        end
    endgenerate

endmodule

// File: tb/strm_xfer_probe_tb.sv
`timescale 1ns/1ps
module strm_xfer_probe_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_valid = 1'b0, t_ready = 1'b0, t_last = 1'b0;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic        arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;

    logic        d_start, d_stop, d_awready, d_wready, d_bvalid, d_arready, d_rvalid;
    logic [1:0]  d_bresp, d_rresp;
    logic [31:0] d_rdata;
    logic        b_start, b_stop, b_awready, b_wready, b_bvalid, b_arready, b_rvalid;
    logic [1:0]  b_bresp, b_rresp;
    logic [31:0] b_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    strm_xfer_probe #(.STATS_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(t_valid), .mon_ready(t_ready), .mon_last(t_last),
        .evt_start(d_start), .evt_stop(d_stop),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(d_awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(d_wready),
        .s_bresp(d_bresp), .s_bvalid(d_bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(d_arready),
        .s_rdata(d_rdata), .s_rresp(d_rresp), .s_rvalid(d_rvalid), .s_rready(rready)
    );

    strm_xfer_probe u_basic (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(t_valid), .mon_ready(t_ready), .mon_last(t_last),
        .evt_start(b_start), .evt_stop(b_stop),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(b_awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(b_wready),
        .s_bresp(b_bresp), .s_bvalid(b_bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(b_arready),
        .s_rdata(b_rdata), .s_rresp(b_rresp), .s_rvalid(b_rvalid), .s_rready(rready)
    );

    // Per entry: {valid, ready, last, expected start, expected stop}.
    localparam logic [4:0] VEC [14] = '{
        5'b000_00, 5'b100_00, 5'b110_10, 5'b010_00, 5'b110_00, 5'b101_00,
        5'b111_01, 5'b111_11, 5'b001_00, 5'b110_10, 5'b110_00, 5'b110_00,
        5'b011_00, 5'b110_00
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic basic_quiet(input string req);
        check(req, {25'd0, b_awready, b_wready, b_bvalid, b_arready, b_rvalid, b_bresp} | b_rdata, 32'd0);
    endtask

    task automatic lite_rd(input logic [3:0] a, output logic [31:0] d, output logic [1:0] rs);
        araddr = a; arvalid = 1'b1; rready = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        for (int n = 0; n < 20 && !d_rvalid; n++) @(negedge clk);
        d = d_rdata; rs = d_rresp;
        @(negedge clk);
    endtask

    task automatic lite_wr(input logic [3:0] a, input logic [31:0] v, output logic [1:0] br);
        awaddr = a; wdata = v; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1; bready = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        for (int n = 0; n < 20 && !d_bvalid; n++) @(negedge clk);
        br = d_bresp;
        basic_quiet("R11 lite outputs during write");
        @(negedge clk);
    endtask

    task automatic beat(input logic v, input logic r, input logic l);
        t_valid = v; t_ready = r; t_last = l;
        @(negedge clk);
        t_valid = 1'b0; t_ready = 1'b0; t_last = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  rs;
        logic [31:0] snap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10).
        check("R10 start after reset", d_start, 0);
        check("R10 stop after reset", d_stop, 0);
        check("R10 rvalid/bvalid after reset", {d_rvalid, d_bvalid}, 0);
        lite_rd(4'h0, rd, rs); check("R10 live count after reset", rd, 0);
        basic_quiet("R11 lite outputs idle");

        // Table walk: events of both variants (R1, R2, R3, R11).
        for (int i = 0; i < 14; i++) begin
            {t_valid, t_ready, t_last} = VEC[i][4:2];
            @(negedge clk);
            check($sformatf("R2 start entry %0d", i), d_start, VEC[i][1]);
            check($sformatf("R3 stop entry %0d", i), d_stop, VEC[i][0]);
            check($sformatf("R11 basic events entry %0d", i), {b_start, b_stop}, VEC[i][1:0]);
        end
        t_valid = 1'b0; t_ready = 1'b0; t_last = 1'b0;

        // Open transfer of 4 beats, previous total 1 (R1, R4, R6).
        lite_rd(4'h0, rd, rs); check("R4 live count mid transfer (R1 stalls ignored)", rd, 4);
        lite_rd(4'h4, rd, rs); check("R6 previous total held", rd, 1);

        // Finish it (R3, R5).
        beat(1'b1, 1'b1, 1'b1);
        check("R3 stop on closing beat", {d_start, d_stop}, 2'b01);
        lite_rd(4'h4, rd, rs); check("R5 total includes TLAST beat", rd, 5);
        lite_rd(4'h0, rd, rs); check("R5 live count restarted", rd, 0);

        // Writes ignored, OKAY (R7).
        lite_wr(4'h0, 32'hFFFF_FFFF, rs); check("R7 bresp offset 0", rs, 2'b00);
        lite_wr(4'h4, 32'h0000_1234, rs); check("R7 bresp offset 4", rs, 2'b00);
        lite_rd(4'h4, rd, rs); check("R7 total unchanged by write", rd, 5);
        lite_rd(4'h0, rd, rs); check("R7 live unchanged by write", rd, 0);

        // Unmapped offsets (R8).
        lite_rd(4'h8, rd, rs); check("R8 offset 8 data", rd, 0); check("R8 offset 8 resp", rs, 0);
        lite_rd(4'hC, rd, rs); check("R8 offset C data", rd, 0);

        // Read data held under back-pressure while beats arrive (R9).
        rready = 1'b0; araddr = 4'h4; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        snap = d_rdata;
        check("R9 captured value", snap, 5);
        t_valid = 1'b1; t_ready = 1'b1; t_last = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 rvalid held", d_rvalid, 1);
            check("R9 rdata stable", d_rdata, snap);
        end
        t_valid = 1'b0; t_ready = 1'b0; t_last = 1'b0;
        rready = 1'b1;
        @(negedge clk);
        check("R9 rvalid dropped after rready", d_rvalid, 0);
        lite_rd(4'h4, rd, rs); check("R5 single-beat total", rd, 1);

        // Reset mid transfer (R10).
        beat(1'b1, 1'b1, 1'b0);
        check("R2 start before reset", d_start, 1);
        beat(1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 events in reset", {d_start, d_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        lite_rd(4'h0, rd, rs); check("R10 live cleared", rd, 0);
        lite_rd(4'h4, rd, rs); check("R10 total cleared", rd, 0);
        beat(1'b1, 1'b1, 1'b0);
        check("R10 start after reset mid transfer", {d_start, d_stop}, 2'b10);
        beat(1'b1, 1'b1, 1'b1);
        check("R3 stop after reset", {d_start, d_stop}, 2'b01);
        lite_rd(4'h4, rd, rs); check("R5 total after reset", rd, 2);
        basic_quiet("R11 lite outputs at end");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule